// File: doc/BRIEF.md
# Six-Bank Frame Capture and Burst Readout Buffer

This block collects one frame of samples into six side-by-side memory banks and then plays the whole frame back through one byte-wide output. After a frame-start pulse it enters a fill phase. In that phase every write strobe stores six bytes, one per bank, at a shared address that steps from 0 to 255. The 256th strobe ends the fill. The block then switches at once to a burst phase and emits all 1536 stored bytes on consecutive clock cycles, bank by bank.

The write strobe comes from outside and sets the slow sample rate. The readout runs at one byte per clock. With a 16 MHz clock the burst takes 96 µs, which fits in the slack left after an 844.8 µs fill inside a 990 µs frame period. A single free-running clock drives everything, and all counters advance only through enable terms. A busy flag tells the surrounding logic when a new frame can be started. A one-cycle done pulse marks the last byte of the burst.

Top module: `frame_burst_buf`

## Requirements
- R1: The buffer holds six banks of 256 bytes, for 1536 bytes per frame. Input lane k of `wr_data` (bits [8k+7:8k], k = 0..5) feeds bank k.
- R2: While filling, each cycle with `wr_stb` high writes all six lanes at one common address. That address starts at 0 for each accepted frame and moves up by one per strobe. The 256th strobe ends the fill.
- R3: Readout beat n (n = 0..1535) carries byte n mod 256 of bank n div 256. An 11-bit read counter produces this order. Its top 3 bits pick the bank: codes 0..5 select banks 0..5, and codes 6 and 7 give a constant 0x00.
- R4: While filling, `rd_valid` stays low and `rd_data` stays 0x00.
- R5: The first beat appears on `rd_valid`/`rd_data` two clock cycles after the edge that samples the final write strobe. The 1536 beats follow on consecutive cycles with no gap.
- R6: `done` is high for exactly one cycle, the cycle of the final beat, and is low at all other times.
- R7: `busy` goes high in the cycle after an accepted frame-start. It stays high through the `done` cycle and is low in the cycle after it.
- R8: Whenever `rd_valid` is low, `rd_data` is 0x00, including after a burst ends and until the next frame is read out.
- R9: A frame-start that arrives while `busy` is high has no effect on the fill address, the stored data or the readout.
- R10: A write strobe outside the fill phase writes nothing and does not move the fill address.
- R11: Synchronous active-high reset returns the block to idle with every output low. A frame started after reset fills from address 0, even if the reset cut a fill short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a fill when the block is not busy |
| wr_stb | input | 1 | One sample period's write strobe during the fill |
| wr_data | input | 48 | Six byte lanes, lane k at bits [8k+7:8k] |
| rd_data | output | 8 | Burst output byte, 0x00 when not valid |
| rd_valid | output | 1 | Marks a valid burst byte |
| busy | output | 1 | High while a frame is being filled or read out |
| done | output | 1 | One-cycle pulse on the final burst byte |

## Verification
A fill address that slips or restarts shows up as rotated or mixed bytes in the next burst. The first wrong byte appears as soon as the burst reaches the damaged entry, so a mismatch shows within one frame. A read counter or bank select that is off is caught on the exact beat where the bank boundary falls in the wrong place. A phase state that leaves the burst early or late changes the beat count, the position of `done`, or the fall of `busy`, all within a cycle of the error. Strobes and frame-starts are injected during fill and burst on purpose, so a leak into stored data is seen in the same frame's readout.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } fbb_state_e;
endpackage

// File: rtl/fbb_bank_ram.sv
// Simple dual-port bank: one write port, one registered read port.
module fbb_bank_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fbb_seq.sv
// Phase control: fill address counter and wide read counter.
module fbb_seq
  import fbb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANKS  = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_start,
  input  logic                      wr_stb,
  input  logic                      hold_off,
  output logic                      wr_en,
  output logic [ADDR_W-1:0]         waddr,
  output logic                      rd_en,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic [$clog2(BANKS)-1:0]  rd_sel,
  output logic                      rd_last,
  output logic                      active,
  output logic                      filling
);
  localparam int SEL_W   = $clog2(BANKS);
  localparam int CNT_W   = SEL_W + ADDR_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LAST_RD = BANKS * DEPTH - 1;

  fbb_state_e       state;
  logic [CNT_W-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      waddr <= '0;
      rcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (frame_start && !hold_off) begin
            state <= ST_FILL;
            waddr <= '0;
          end
        end
        ST_FILL: begin
          if (wr_stb) begin
            waddr <= waddr + 1'b1;
            if (waddr == ADDR_W'(DEPTH - 1)) begin
              state <= ST_DRAIN;
              rcnt  <= '0;
            end
          end
        end
        ST_DRAIN: begin
          if (rcnt == CNT_W'(LAST_RD)) begin
            state <= ST_IDLE;
            rcnt  <= '0;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign filling = (state == ST_FILL);
  assign active  = (state != ST_IDLE);
  assign wr_en   = filling && wr_stb;
  assign rd_en   = (state == ST_DRAIN);
  assign rd_sel  = rcnt[CNT_W-1 -: SEL_W];
  assign rd_addr = rcnt[ADDR_W-1:0];
  assign rd_last = rd_en && (rcnt == CNT_W'(LAST_RD));

  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL && !wr_stb) |=> (state == ST_FILL && $stable(waddr)));

  // R3
  rcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |-> (rcnt <= CNT_W'(LAST_RD)));

  // R10
  idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |=> $stable(waddr));
endmodule

// File: rtl/fbb_out_mux.sv
// Aligns select with the bank read latency, picks a bank, registers output.
module fbb_out_mux #(
  parameter int DATA_W = 8,
  parameter int BANKS  = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [$clog2(BANKS)-1:0]  rd_sel,
  input  logic                      rd_last,
  input  logic [BANKS*DATA_W-1:0]   bank_q,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_valid,
  output logic                      done,
  output logic                      pipe_busy
);
  localparam int SEL_W = $clog2(BANKS);

  logic             v1, last1;
  logic [SEL_W-1:0] sel1;
  logic [SEL_W-1:0] eff_sel;
  logic [DATA_W-1:0] pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      last1 <= 1'b0;
      sel1  <= '1;
    end else begin
      v1    <= rd_en;
      last1 <= rd_last;
      sel1  <= rd_sel;
    end
  end

  // Outside a burst the select is parked on an all-ones code, which maps to zero.
  assign eff_sel = v1 ? sel1 : '1;

  always_comb begin
    pick = '0;
    for (int k = 0; k < BANKS; k++) begin
      if (v1 && eff_sel == SEL_W'(k)) pick = bank_q[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_data  <= pick;
      rd_valid <= v1;
      done     <= last1;
    end
  end

  assign pipe_busy = v1 | rd_valid;

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  // R6
  done_beat_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> rd_valid);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  burst_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !done) |=> rd_valid);
endmodule

// File: rtl/frame_burst_buf.sv
module frame_burst_buf #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int BANKS  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic                    wr_stb,
  input  logic [BANKS*DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid,
  output logic                    busy,
  output logic                    done
);
  localparam int SEL_W = $clog2(BANKS);

  logic                    wr_en, rd_en, rd_last, active, filling, pipe_busy;
  logic [ADDR_W-1:0]       waddr, rd_addr;
  logic [SEL_W-1:0]        rd_sel;
  logic [BANKS*DATA_W-1:0] bank_q;

  fbb_seq #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_seq (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wr_stb(wr_stb),
    .hold_off(pipe_busy), .wr_en(wr_en), .waddr(waddr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_sel(rd_sel), .rd_last(rd_last),
    .active(active), .filling(filling)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    fbb_bank_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .we(wr_en), .waddr(waddr),
      .wdata(wr_data[b*DATA_W +: DATA_W]),
      .re(rd_en), .raddr(rd_addr),
      .rdata(bank_q[b*DATA_W +: DATA_W])
    );
  end

  fbb_out_mux #(.DATA_W(DATA_W), .BANKS(BANKS)) u_mux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel), .rd_last(rd_last),
    .bank_q(bank_q), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .pipe_busy(pipe_busy)
  );

  assign busy = active | pipe_busy;

  // R4
  no_fill_leak_chk: assert property (@(posedge clk) disable iff (rst)
    filling |-> (!rd_valid && rd_data == '0));

  // R7
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

// File: tb/tb_frame_burst_buf.sv
module tb_frame_burst_buf;
  localparam int DW    = 8;
  localparam int BANKS = 6;
  localparam int DEPTH = 256;
  localparam int TOTAL = BANKS * DEPTH;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 frame_start = 1'b0;
  logic                 wr_stb = 1'b0;
  logic [BANKS*DW-1:0]  wr_data = '0;
  logic [DW-1:0]        rd_data;
  logic                 rd_valid, busy, done;

  frame_burst_buf #(.DATA_W(DW), .ADDR_W(8), .BANKS(BANKS)) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] exp_mem [TOTAL];
  int beat = 0;
  int unsigned last_stb_cyc = 0;
  bit mon_en = 1'b0;
  int done_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [DW-1:0] pat_byte(input int mode, input int b, input int a);
    case (mode)
      0: pat_byte = DW'((a * 7 + b * 41 + 3) & 8'hFF);
      1: pat_byte = 8'hFF;
      default: pat_byte = DW'($urandom & 8'hFF);
    endcase
  endfunction

  // Output monitor: bank-major order, zero when idle, done on final beat.
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (rd_valid) begin
        if (beat < TOTAL) begin
          check(rd_data == exp_mem[beat], "R3 burst byte", int'(rd_data), int'(exp_mem[beat]));
          if (beat == 0)
            check(cyc == last_stb_cyc + 2, "R5 first beat latency", int'(cyc - last_stb_cyc), 2);
        end
        check(done == (beat == TOTAL - 1), "R6 done position", int'(done), int'(beat == TOTAL - 1));
        if (done) done_cnt++;
        beat++;
      end else begin
        check(rd_data == '0, "R8 idle output zero", int'(rd_data), 0);
        check(done == 1'b0, "R6 done only with beat", int'(done), 0);
        if (beat > 0 && beat < TOTAL)
          check(1'b0, "R5 gap inside burst", beat, TOTAL);
      end
    end
  end

  task automatic fill_frame(input int mode, input int max_gap, input bit inject, input int n_stb);
    for (int b = 0; b < BANKS; b++)
      for (int a = 0; a < DEPTH; a++)
        exp_mem[b*DEPTH + a] = pat_byte(mode, b, a);
    beat = 0;
    done_cnt = 0;
    // R10: stray strobes while idle must not move the fill address
    if (inject) begin
      repeat (3) begin
        wr_data = {BANKS*DW{1'b1}} ^ BANKS*DW'($urandom);
        wr_stb = 1'b1;
        @(negedge clk);
      end
      wr_stb = 1'b0;
    end
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    for (int a = 0; a < n_stb; a++) begin
      int gap = (max_gap == 0) ? 0 : int'($urandom % (max_gap + 1));
      for (int g = 0; g < gap; g++) begin
        wr_data = BANKS*DW'({$urandom, $urandom});
        frame_start = inject && ($urandom % 2 == 0); // R9: ignored while filling
        @(negedge clk);
        check(rd_valid == 1'b0 && rd_data == '0, "R4 quiet during fill", int'(rd_valid), 0);
      end
      frame_start = 1'b0;
      for (int b = 0; b < BANKS; b++) wr_data[b*DW +: DW] = exp_mem[b*DEPTH + a];
      wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      last_stb_cyc = cyc;
    end
  endtask

  task automatic drain_frame(input bit inject);
    int guard = 0;
    while (beat < TOTAL && guard < 3 * TOTAL) begin
      if (inject) begin
        // R10 and R9: strobes and starts during the burst must not disturb it
        wr_stb = ($urandom % 3 == 0);
        wr_data = BANKS*DW'({$urandom, $urandom});
        frame_start = (beat < TOTAL - 8) && ($urandom % 5 == 0);
      end
      @(negedge clk);
      guard++;
    end
    wr_stb = 1'b0;
    frame_start = 1'b0;
    check(beat == TOTAL, "R5 beat count", beat, TOTAL);
    check(done_cnt == 1, "R6 single done", done_cnt, 1);
    @(negedge clk);
    check(busy == 1'b0, "R7 busy low after done", int'(busy), 0);
    check(rd_valid == 1'b0 && rd_data == '0, "R8 output zero after burst", int'(rd_data), 0);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0 && rd_data == '0 && busy == 1'b0 && done == 1'b0,
          "R11 reset state", int'({rd_valid, busy, done}), 0);
    rst = 1'b0;
    mon_en = 1'b1;
    @(negedge clk);

    // R1 R2 directed pattern, back-to-back strobes
    fill_frame(0, 0, 1'b0, DEPTH);
    drain_frame(1'b0);

    // random data, random gaps, injected starts and strobes
    fill_frame(2, 3, 1'b1, DEPTH);
    drain_frame(1'b1);

    // R11: reset in the middle of a fill, then a fresh all-ones frame
    fill_frame(2, 1, 1'b0, 100);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0 && rd_valid == 1'b0 && rd_data == '0, "R11 reset mid-fill", int'(busy), 0);
    fill_frame(1, 2, 1'b1, DEPTH);
    drain_frame(1'b1);

    // one more random frame right after the previous one
    fill_frame(2, 2, 1'b1, DEPTH);
    drain_frame(1'b0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule